// File: doc/BRIEF.md
# Dual-Mode Timer Waveform Generator

This block is a 16-bit up-counter with a clock prescaler, a period value and a set of compare channels, and it produces pin-level waveforms in one of two modes. In toggle-frequency mode, channel 0's compare value acts as the counter's top. Channel 0's output flips each time the counter reaches that top, which gives a square wave whose frequency the compare value sets. In single-slope PWM mode, the period value sets the top. Each channel's output is high from the bottom of the count until the counter reaches that channel's compare value.

Software-visible values are loaded through a single write port. The period and compare values go into shadow copies, and the shadow copies move to the active copies only when the counter wraps from top to zero. This keeps the edges inside a period consistent. The counter itself can be written directly. Each pin combines the channel waveform with a fallback port value, an invert bit and a direction bit.

Top module: `wavegen_timer`

## Requirements
- R1: `presc_sel` codes 0,1,2,3,4,5,6 advance the counter once every 1,2,4,8,64,256,1024 clocks. Code 7 halts the counter.
- R2: The counter increases by one per prescaler tick. A write to address 0 loads `cnt_o` at the next clock edge and takes priority over a tick.
- R3: With `mode`=2 (PWM), the counter wraps from the active period value to 0, so one period lasts period+1 ticks.
- R4: In PWM mode a channel's waveform is high while the counter is below its compare value. A compare value of 0 gives constant low. A compare value above the period gives constant high.
- R5: With `mode`=1 (frequency), the counter's top is channel 0's compare value, and channel 0's waveform toggles at each match. Each half period lasts N·(CC0+1) clocks, where N is the prescaler ratio.
- R6: Writes to address 1 (period) and address 2+k (compare k) are held in shadow registers. They become active only when the counter wraps from top to 0.
- R7: A channel's waveform drives its pin only when the mode is 1 or 2 and `ch_en[k]` is set. In mode 1, this applies to channel 0 only. In every other case the pin carries `port_out[k]`.
- R8: When `pin_inv[k]` is 1, the value on pin k is inverted.
- R9: When `pin_dir[k]` is 0, `pin_out[k]` is 0.
- R10: Reset clears the counter, the compare values and the toggle state, and sets the period to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | 0 counter, 1 period, 2+k compare k |
| wr_data | input | W | Write data |
| mode | input | 2 | 0 off, 1 frequency, 2 PWM, 3 off |
| presc_sel | input | 3 | Prescaler ratio code |
| ch_en | input | NCH | Channel waveform enable |
| pin_inv | input | NCH | Pin invert |
| pin_dir | input | NCH | Pin direction, 1 = output |
| port_out | input | NCH | Fallback pin value |
| cnt_o | output | W | Current counter value |
| pin_out | output | NCH | Pin values |

## Verification
The hardest situation to reach is a shadow update landing on a specific wrap while the old values still govern the period in progress. After reset the period is all ones, so a natural wrap would take 65536 ticks. The stimulus forces that first wrap by writing the counter to its top. It then writes a new period or compare value at a chosen count. It follows the counter through the next two wraps and samples the pin mid-period, which shows that the old value still rules until the wrap and the new value rules after it.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

    typedef enum logic [1:0] {
        WG_OFF = 2'd0,
        WG_FRQ = 2'd1,
        WG_PWM = 2'd2,
        WG_RSV = 2'd3
    } wg_mode_e;

    typedef struct packed {
        logic en;
        logic inv;
        logic dir;
        logic port;
    } pin_ctl_t;

    localparam int PSC_W    = 10;
    localparam int ADDR_CNT = 0;
    localparam int ADDR_PER = 1;
    localparam int ADDR_CC0 = 2;
    localparam logic [2:0] PSC_HALT = 3'd7;

    function automatic logic [PSC_W-1:0] presc_mask(input logic [2:0] sel);
        case (sel)
            3'd0:    return PSC_W'(0);
            3'd1:    return PSC_W'(1);
            3'd2:    return PSC_W'(3);
            3'd3:    return PSC_W'(7);
            3'd4:    return PSC_W'(63);
            3'd5:    return PSC_W'(255);
            default: return PSC_W'(1023);
        endcase
    endfunction

endpackage

// File: rtl/wgt_prescaler.sv
module wgt_prescaler
    import wgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PSC_W-1:0] pc;
    logic [PSC_W-1:0] mask;

    assign mask = presc_mask(sel);
    assign tick = (sel != PSC_HALT) && ((pc & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc + 1'b1;
    end
endmodule

// File: rtl/wgt_counter.sv
module wgt_counter
    import wgt_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 4,
    parameter int AW  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  wg_mode_e                mode,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [W-1:0]            wr_data,
    output logic [W-1:0]            cnt,
    output logic [NCH-1:0][W-1:0]   cc_act
);
    localparam logic [AW-1:0] A_CNT = AW'(ADDR_CNT);
    localparam logic [AW-1:0] A_PER = AW'(ADDR_PER);

    logic [W-1:0]          per_buf, per_act, top;
    logic [NCH-1:0][W-1:0] cc_buf;
    logic                  cnt_wr, wrap;

    assign top    = (mode == WG_FRQ) ? cc_act[0] : per_act;
    assign cnt_wr = wr_en && (wr_addr == A_CNT);
    assign wrap   = tick && !cnt_wr && (cnt == top);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            per_buf <= '1;
            per_act <= '1;
            cc_buf  <= '0;
            cc_act  <= '0;
        end else begin
            if (wr_en && wr_addr == A_PER) per_buf <= wr_data;
            for (int k = 0; k < NCH; k++) begin
                if (wr_en && wr_addr == AW'(ADDR_CC0 + k)) cc_buf[k] <= wr_data;
            end
            if (cnt_wr)     cnt <= wr_data;
            else if (wrap)  cnt <= '0;
            else if (tick)  cnt <= cnt + 1'b1;
            if (wrap) begin
                per_act <= per_buf;
                cc_act  <= cc_buf;
            end
        end
    end
endmodule

// File: rtl/wgt_channel.sv
module wgt_channel
    import wgt_pkg::*;
#(
    parameter int W       = 16,
    parameter bit FRQ_SRC = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  wg_mode_e     mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cc,
    input  pin_ctl_t     ctl,
    output logic         pin
);
    logic tg, wg, drive, level;

    always_ff @(posedge clk) begin
        if (rst || mode != WG_FRQ) tg <= 1'b0;
        else if (tick && cnt == cc) tg <= ~tg;
    end

    assign wg    = (mode == WG_FRQ) ? tg : (cnt < cc);
    assign drive = ctl.en && ((mode == WG_PWM) || (mode == WG_FRQ && FRQ_SRC));
    assign level = drive ? wg : ctl.port;
    assign pin   = ctl.dir & (level ^ ctl.inv);
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
    import wgt_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 4,
    parameter int AW  = $clog2(NCH + 2)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic [1:0]     mode,
    input  logic [2:0]     presc_sel,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] pin_inv,
    input  logic [NCH-1:0] pin_dir,
    input  logic [NCH-1:0] port_out,
    output logic [W-1:0]   cnt_o,
    output logic [NCH-1:0] pin_out
);
    wg_mode_e              md;
    logic                  tick;
    logic [W-1:0]          cnt;
    logic [NCH-1:0][W-1:0] cc_act;

    assign md    = wg_mode_e'(mode);
    assign cnt_o = cnt;

    wgt_prescaler u_psc (
        .clk (clk),
        .rst (rst),
        .sel (presc_sel),
        .tick(tick)
    );

    wgt_counter #(.W(W), .NCH(NCH), .AW(AW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .mode   (md),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cnt    (cnt),
        .cc_act (cc_act)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        pin_ctl_t ctl;
        assign ctl = '{en: ch_en[k], inv: pin_inv[k], dir: pin_dir[k], port: port_out[k]};
        wgt_channel #(.W(W), .FRQ_SRC(k == 0)) u_ch (
            .clk (clk),
            .rst (rst),
            .tick(tick),
            .mode(md),
            .cnt (cnt),
            .cc  (cc_act[k]),
            .ctl (ctl),
            .pin (pin_out[k])
        );
    end
endmodule

// File: rtl/wgt_checker.sv
module wgt_checker #(
    parameter int W   = 16,
    parameter int NCH = 4,
    parameter int AW  = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  wr_en,
    input logic [AW-1:0]         wr_addr,
    input logic [1:0]            mode,
    input logic [2:0]            presc_sel,
    input logic [W-1:0]          cnt,
    input logic [NCH-1:0][W-1:0] cc_act,
    input logic [NCH-1:0]        ch_en,
    input logic [NCH-1:0]        pin_inv,
    input logic [NCH-1:0]        pin_dir,
    input logic [NCH-1:0]        pin_out
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_addr == '0);

    assert_div1_R1: assert property (@(posedge clk) disable iff (rst)
        presc_sel == 3'd0 |-> tick);

    assert_halt_R1: assert property (@(posedge clk) disable iff (rst)
        presc_sel == 3'd7 |-> !tick);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && mode == 2'd1 && cnt != cc_act[0])
        |=> cnt == $past(cnt) + 1'b1);

    assert_frq_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && mode == 2'd1 && cnt == cc_act[0]) |=> cnt == '0);

    assert_frq_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 2'd1 && cnt == cc_act[0] && ch_en[0] && pin_dir[0])
        |=> (mode != 2'd1 || !ch_en[0] || !pin_dir[0] || !$stable(pin_inv[0])
             || pin_out[0] != $past(pin_out[0])));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && !(tick && !cnt_wr && cnt == cc_act[0])) |=> $stable(cc_act));

    for (genvar k = 0; k < NCH; k++) begin : g_pin
        assert_dir_off_R9: assert property (@(posedge clk) disable iff (rst)
            !pin_dir[k] |-> !pin_out[k]);
    end
endmodule

bind wavegen_timer wgt_checker #(.W(W), .NCH(NCH), .AW(AW)) u_wgt_checker (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .mode     (mode),
    .presc_sel(presc_sel),
    .cnt      (cnt),
    .cc_act   (cc_act),
    .ch_en    (ch_en),
    .pin_inv  (pin_inv),
    .pin_dir  (pin_dir),
    .pin_out  (pin_out)
);

// File: tb/wavegen_timer_bench.sv
module wavegen_timer_bench;
    localparam int W = 16, NCH = 4, AW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0] mode = 2'd0;
    logic [2:0] presc_sel = 3'd0;
    logic [NCH-1:0] ch_en = '0, pin_inv = '0, pin_dir = '0, port_out = '0;
    logic [W-1:0] cnt_o;
    logic [NCH-1:0] pin_out;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wavegen_timer #(.W(W), .NCH(NCH), .AW(AW)) u_wavegen_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode), .presc_sel(presc_sel), .ch_en(ch_en), .pin_inv(pin_inv),
        .pin_dir(pin_dir), .port_out(port_out), .cnt_o(cnt_o), .pin_out(pin_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 5000 && int'(cnt_o) != v; i++) step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        step(3);
        // R10: reset state
        chk("R10 cnt at reset", int'(cnt_o), 0);
        chk("R10 pins at reset", int'(pin_out), 0);
        rst = 1'b0;
        mode = 2'd2;
        // R6: reset period is all ones; force the wrap to load period 7
        wr(1, 7);
        wr(0, 16'hFFFF);
        step(2);
        chk("R6 forced wrap loads period", int'(cnt_o) <= 7, 1);

        // R1: prescaler ratios
        for (int s = 0; s < 7; s++) begin
            int ratio, prev, n, changes;
            ratio = (s < 4) ? (1 << s) : (s == 4 ? 64 : (s == 5 ? 256 : 1024));
            presc_sel = 3'(s);
            prev = int'(cnt_o);
            for (int i = 0; i < 3000 && int'(cnt_o) == prev; i++) step(1);
            prev = int'(cnt_o); n = 0; changes = 0;
            while (changes < 4 && n < 6000) begin
                step(1); n++;
                if (int'(cnt_o) != prev) begin changes++; prev = int'(cnt_o); end
            end
            chk($sformatf("R1 ratio code %0d", s), n, 4 * ratio);
        end
        begin
            int held;
            presc_sel = 3'd7;
            step(2);
            held = int'(cnt_o);
            step(40);
            chk("R1 halt code 7", int'(cnt_o), held);
        end

        // R2 / R3: counting by one and wrapping at period 7
        presc_sel = 3'd0;
        wait_cnt(5);
        step(1); chk("R2 step +1", int'(cnt_o), 6);
        step(1); chk("R3 reaches period", int'(cnt_o), 7);
        step(1); chk("R3 wraps to zero", int'(cnt_o), 0);

        // R4 / R8: duty sweep, ch1 plain, ch2 inverted
        ch_en = 4'b0110; pin_dir = 4'b0110; pin_inv = 4'b0100;
        for (int c = 0; c <= 9; c++) begin
            int h1, h2;
            wr(3, c); wr(4, 9 - c);
            step(20);
            h1 = 0; h2 = 0;
            for (int i = 0; i < 32; i++) begin
                step(1);
                h1 += pin_out[1]; h2 += pin_out[2];
            end
            chk($sformatf("R4 duty cc=%0d", c), h1, 4 * ((c < 8) ? c : 8));
            chk($sformatf("R8 inverted duty cc=%0d", 9 - c), h2,
                32 - 4 * (((9 - c) < 8) ? (9 - c) : 8));
        end

        // R6: period write takes effect at the following wrap
        begin
            int mx;
            wait_cnt(2);
            wr(1, 20);
            mx = 0;
            for (int i = 0; i < 100 && int'(cnt_o) != 0; i++) begin
                if (int'(cnt_o) > mx) mx = int'(cnt_o);
                step(1);
            end
            chk("R6 old period until wrap", mx, 7);
            step(1); mx = 0;
            for (int i = 0; i < 100 && int'(cnt_o) != 0; i++) begin
                if (int'(cnt_o) > mx) mx = int'(cnt_o);
                step(1);
            end
            chk("R6 new period after wrap", mx, 20);
        end
        // R6: compare write waits for wrap
        pin_inv = '0;
        wr(3, 5);
        step(50);
        wait_cnt(8);
        wr(3, 15);
        wait_cnt(12);
        chk("R6 old compare holds mid-period", int'(pin_out[1]), 0);
        step(2);
        wait_cnt(12);
        chk("R6 new compare after wrap", int'(pin_out[1]), 1);

        // R2: direct counter write wins over tick
        wr(1, 100);
        step(30);
        wr(0, 50);
        chk("R2 direct write", int'(cnt_o), 50);
        step(1);
        chk("R2 counts after write", int'(cnt_o), 51);

        // R5: frequency mode half periods
        mode = 2'd1;
        wr(0, 0);
        ch_en = 4'b0011; pin_dir = 4'b0011; pin_inv = '0;
        for (int t = 0; t < 6; t++) begin
            int s, v, n, prev;
            s = (t < 4) ? 0 : (t == 4 ? 1 : 3);
            v = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 2 : (t == 3) ? 5 : (t == 4) ? 3 : 2;
            presc_sel = 3'(s);
            wr(2, v);
            step(300);
            for (int h = 0; h < 2; h++) begin
                prev = pin_out[0];
                for (int i = 0; i < 2000 && pin_out[0] == prev; i++) step(1);
                prev = pin_out[0]; n = 0;
                while (pin_out[0] == prev && n < 2000) begin step(1); n++; end
                chk($sformatf("R5 half period code %0d cc %0d", s, v), n, (1 << s) * (v + 1));
            end
        end
        // R7: channel 1 falls back to port value in frequency mode
        port_out = 4'b0010; step(2);
        chk("R7 frq mode ch1 fallback high", int'(pin_out[1]), 1);
        port_out = 4'b0000; step(2);
        chk("R7 frq mode ch1 fallback low", int'(pin_out[1]), 0);

        // R7 / R8 / R9: pin gating, ch1 waveform constant high
        presc_sel = 3'd0; mode = 2'd2;
        wr(3, 16'hFFFF);
        step(150);
        ch_en = 4'b0010; pin_dir = 4'b0010; pin_inv = 4'b0000; step(2);
        chk("R4 cc above period constant high", int'(pin_out[1]), 1);
        pin_inv = 4'b0010; step(2);
        chk("R8 invert waveform", int'(pin_out[1]), 0);
        pin_inv = 4'b0000; ch_en = 4'b0000; port_out = 4'b0000; step(2);
        chk("R7 disabled uses port low", int'(pin_out[1]), 0);
        port_out = 4'b0010; step(2);
        chk("R7 disabled uses port high", int'(pin_out[1]), 1);
        pin_inv = 4'b0010; step(2);
        chk("R8 invert port value", int'(pin_out[1]), 0);
        pin_inv = 4'b0000; ch_en = 4'b0010; port_out = 4'b0000; pin_dir = 4'b0000; step(2);
        chk("R9 direction input gives 0", int'(pin_out[1]), 0);
        pin_dir = 4'b0010; mode = 2'd0; step(2);
        chk("R7 mode off uses port", int'(pin_out[1]), 0);
        mode = 2'd3; port_out = 4'b0010; step(2);
        chk("R7 mode 3 uses port", int'(pin_out[1]), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule